// File: doc/BRIEF.md
# Text Cursor Visibility Generator

This block decides, for every pixel row of every character cell a display controller walks through, whether the text cursor should be drawn there. It compares the address of the cell being fetched against a programmed cursor address. It then checks that the current scanline within the character row falls inside a programmed vertical band. Finally it gates the result with a blink phase taken from a frame counter that steps once per frame-start pulse.

Software programs three things. The first is a mode byte: bits 6..5 pick one of four display modes, and bits 4..0 give the first scanline of the cursor. The second is an end byte, which holds the scanline one past the last cursor scanline. The third is the cursor address, written as a high half and a low half. The video pipeline supplies the cell address, the scanline and the frame-start pulse. The one-bit result feeds the pixel mixer one clock later.

Top module: `cur_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the output `cursor_on` is 0. Reset also clears the frame counter to zero.
- R2: Mode field `mode_cfg[6:5]` = 00 (steady) shows the cursor in every frame, whatever the frame count.
- R3: Mode field 01 (hidden) never shows the cursor, even when the address and scanline both match.
- R4: Mode field 10 (fast blink) shows the cursor while bit 3 of the frame count is 0. The cursor is therefore visible for 8 frames and then hidden for 8 frames, starting visible after reset.
- R5: Mode field 11 (normal blink) shows the cursor while bit 4 of the frame count is 0. The cursor is therefore visible for 16 frames and then hidden for 16 frames, starting visible after reset.
- R6: The first cursor scanline is `mode_cfg[4:0]`. Scanlines below it are not shown, and `mode_cfg[7]` has no effect.
- R7: The end value is `end_cfg[5:0]` and counts as last scanline plus one. A scanline equal to end-1 is shown, a scanline equal to end is not, and `end_cfg[7:6]` has no effect. An end value of 32 permits scanline 31.
- R8: If start is greater than or equal to end, the cursor is never shown.
- R9: The cursor address is {`cur_hi`, `cur_lo`}. The cursor is shown only when `cell_addr` equals it in all 16 bits, so a mismatch in either byte hides it.
- R10: `cursor_on` is registered. It reflects the inputs and frame count of the previous clock cycle.
- R11: The 5-bit frame counter advances by one only on a clock where `frame_start` is 1, and wraps from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pipeline clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| mode_cfg | input | 8 | Mode byte: [6:5] display mode, [4:0] first scanline |
| end_cfg | input | 8 | End byte: [5:0] last scanline plus one |
| cur_hi | input | 8 | Upper byte of cursor address |
| cur_lo | input | 8 | Lower byte of cursor address |
| cell_addr | input | 16 | Video memory address of the current cell |
| scan_line | input | 5 | Scanline within the current character row |
| cursor_on | output | 1 | Cursor visible on this pixel row of this cell |

## Verification
The bench builds the block with its default parameters: a 16-bit address split into two bytes, 5-bit scanlines, and blink toggles every 8 and 16 frames. With these values the whole blink cycle, including the wrap of the 5-bit frame counter after 32 pulses, takes only a few hundred clocks. The scanline edges at 0, 31 and an end of 32 can also be reached directly. Each of the four modes is therefore checked at every frame count on either side of its phase changes.

// File: rtl/cur_pkg.sv
// Shared definitions for the cursor visibility generator.
// Assumes the mode field sits in bits 6..5 of the mode byte.
package cur_pkg;

    typedef enum logic [1:0] {
        CM_STEADY = 2'b00,
        CM_HIDDEN = 2'b01,
        CM_FAST   = 2'b10,
        CM_SLOW   = 2'b11
    } cur_mode_e;

    localparam int MODE_LSB = 5;
    localparam int MODE_MSB = 6;

endpackage

// File: rtl/cur_blink.sv
// Frame counter and blink phase selection.
// Counts frame-start pulses and reports whether the chosen mode
// lets the cursor show in the current frame. Assumes FAST_SHIFT < SLOW_SHIFT.
module cur_blink #(
    parameter int FAST_SHIFT = 3,
    parameter int SLOW_SHIFT = 4,
    localparam int CNT_W = SLOW_SHIFT + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  cur_pkg::cur_mode_e  mode,
    output logic                phase_on,
    output logic [CNT_W-1:0]    frm_cnt
);
    import cur_pkg::*;

    // Advance the frame count once per frame-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frm_cnt <= '0;
        else if (frame_start)
            frm_cnt <= frm_cnt + 1'b1;
    end

    // Pick the visibility phase that the current mode asks for.
    always_comb begin
        unique case (mode)
            CM_STEADY: phase_on = 1'b1;
            CM_HIDDEN: phase_on = 1'b0;
            CM_FAST:   phase_on = ~frm_cnt[FAST_SHIFT];
            CM_SLOW:   phase_on = ~frm_cnt[SLOW_SHIFT];
            default:   phase_on = 1'b0;
        endcase
    end

endmodule

// File: rtl/cur_window.sv
// Vertical band test: scanline must lie in [start, end).
// The end value is one wider than a scanline so that it can mark
// the row just past the last line. An empty band never matches.
module cur_window #(
    parameter int LINE_W = 5
) (
    input  logic [LINE_W-1:0] start_line,
    input  logic [LINE_W:0]   end_line,
    input  logic [LINE_W-1:0] scan_line,
    output logic              in_band
);
    logic [LINE_W:0] scan_x;
    logic [LINE_W:0] start_x;

    // Compare everything at the wider width so end = 2**LINE_W works.
    always_comb begin
        scan_x  = {1'b0, scan_line};
        start_x = {1'b0, start_line};
        in_band = (scan_x >= start_x) && (scan_x < end_line);
    end

endmodule

// File: rtl/cur_match.sv
// Address comparator, one equality lane per byte.
// The cursor address arrives as two halves; the comparator joins them
// and requires every lane to match. Assumes ADDR_W is a multiple of 8.
module cur_match #(
    parameter int ADDR_W = 16,
    localparam int HALF_W = ADDR_W / 2,
    localparam int LANES = ADDR_W / 8
) (
    input  logic [HALF_W-1:0] cur_hi,
    input  logic [HALF_W-1:0] cur_lo,
    input  logic [ADDR_W-1:0] cell_addr,
    output logic              addr_hit
);
    logic [ADDR_W-1:0] cur_full;
    logic [LANES-1:0]  lane_eq;

    assign cur_full = {cur_hi, cur_lo};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One byte-wide equality test per lane.
        assign lane_eq[g] = (cur_full[g*8 +: 8] == cell_addr[g*8 +: 8]);
    end

    // All lanes must agree for a hit.
    assign addr_hit = &lane_eq;

endmodule

// File: rtl/cur_gen.sv
// Cursor visibility generator top level.
// Splits the mode and end bytes into fields, combines the address hit,
// the scanline band and the blink phase, and registers the result.
// Assumes the mode and end bytes are 8 bits wide and LINE_W <= 5.
module cur_gen #(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 5,
    parameter int FAST_SHIFT = 3,
    parameter int SLOW_SHIFT = 4,
    localparam int HALF_W = ADDR_W / 2,
    localparam int CNT_W = SLOW_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [7:0]        mode_cfg,
    input  logic [7:0]        end_cfg,
    input  logic [HALF_W-1:0] cur_hi,
    input  logic [HALF_W-1:0] cur_lo,
    input  logic [ADDR_W-1:0] cell_addr,
    input  logic [LINE_W-1:0] scan_line,
    output logic              cursor_on
);
    import cur_pkg::*;

    cur_mode_e         mode;
    logic [LINE_W-1:0] start_line;
    logic [LINE_W:0]   end_line;
    logic              phase_on;
    logic              in_band;
    logic              addr_hit;
    logic [CNT_W-1:0]  frm_cnt;

    // Pull the fields out of the configuration bytes.
    always_comb begin
        mode       = cur_mode_e'(mode_cfg[MODE_MSB:MODE_LSB]);
        start_line = mode_cfg[LINE_W-1:0];
        end_line   = end_cfg[LINE_W:0];
    end

    cur_blink #(
        .FAST_SHIFT (FAST_SHIFT),
        .SLOW_SHIFT (SLOW_SHIFT)
    ) u_blink (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .mode        (mode),
        .phase_on    (phase_on),
        .frm_cnt     (frm_cnt)
    );

    cur_window #(
        .LINE_W (LINE_W)
    ) u_window (
        .start_line (start_line),
        .end_line   (end_line),
        .scan_line  (scan_line),
        .in_band    (in_band)
    );

    cur_match #(
        .ADDR_W (ADDR_W)
    ) u_match (
        .cur_hi    (cur_hi),
        .cur_lo    (cur_lo),
        .cell_addr (cell_addr),
        .addr_hit  (addr_hit)
    );

    // Register the final visibility decision for the pixel mixer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cursor_on <= 1'b0;
        else
            cursor_on <= addr_hit & in_band & phase_on;
    end

endmodule

// File: rtl/cur_gen_chk.sv
// Property checker for cur_gen, attached by bind below.
// Observes ports and the frame counter only; drives nothing.
module cur_gen_chk #(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 5,
    parameter int SLOW_SHIFT = 4,
    localparam int HALF_W = ADDR_W / 2,
    localparam int CNT_W = SLOW_SHIFT + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic [7:0]        mode_cfg,
    input logic [7:0]        end_cfg,
    input logic [HALF_W-1:0] cur_hi,
    input logic [HALF_W-1:0] cur_lo,
    input logic [ADDR_W-1:0] cell_addr,
    input logic [LINE_W-1:0] scan_line,
    input logic              cursor_on,
    input logic [CNT_W-1:0]  frm_cnt
);
    logic [LINE_W:0] start_x;
    logic [LINE_W:0] scan_x;
    logic [LINE_W:0] end_x;

    always_comb begin
        start_x = {1'b0, mode_cfg[LINE_W-1:0]};
        scan_x  = {1'b0, scan_line};
        end_x   = end_cfg[LINE_W:0];
    end

    // R3
    hidden_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cfg[6:5] == 2'b01) |=> !cursor_on);

    // R8
    empty_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_x >= end_x) |=> !cursor_on);

    // R7
    band_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_on |-> ($past(scan_x) < $past(end_x)) && ($past(scan_x) >= $past(start_x)));

    // R9
    addr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_on |-> ($past(cell_addr) == $past({cur_hi, cur_lo})));

    // R11
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && rst_n) |=> $stable(frm_cnt));

    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && rst_n) |=> (frm_cnt == $past(frm_cnt) + 1'b1));

endmodule

bind cur_gen cur_gen_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_W     (LINE_W),
    .SLOW_SHIFT (SLOW_SHIFT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .mode_cfg    (mode_cfg),
    .end_cfg     (end_cfg),
    .cur_hi      (cur_hi),
    .cur_lo      (cur_lo),
    .cell_addr   (cell_addr),
    .scan_line   (scan_line),
    .cursor_on   (cursor_on),
    .frm_cnt     (frm_cnt)
);

// File: tb/sim_cur_gen.sv
// Self-checking bench for cur_gen with default parameters.
module sim_cur_gen;
    localparam int CLK_P = 10;
    localparam int NVEC  = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [7:0]  mode_cfg = 8'h00;
    logic [7:0]  end_cfg = 8'h08;
    logic [7:0]  cur_hi = 8'h12;
    logic [7:0]  cur_lo = 8'h34;
    logic [15:0] cell_addr = 16'h0000;
    logic [4:0]  scan_line = 5'd0;
    logic        cursor_on;

    int n_chk = 0;
    int n_fail = 0;

    // {mode, end, hi, lo, cell[15:0], scan, expected}
    localparam logic [63:0] VEC [NVEC] = '{
        {8'h00, 8'h08, 8'h12, 8'h34, 16'h1234, 8'd0,  8'd1}, // R2 steady, start 0
        {8'h00, 8'h08, 8'h12, 8'h34, 16'h1234, 8'd7,  8'd1}, // R7 end-1 shown
        {8'h00, 8'h08, 8'h12, 8'h34, 16'h1234, 8'd8,  8'd0}, // R7 end not shown
        {8'h03, 8'h08, 8'h12, 8'h34, 16'h1234, 8'd2,  8'd0}, // R6 below start
        {8'h03, 8'h08, 8'h12, 8'h34, 16'h1234, 8'd3,  8'd1}, // R6 at start
        {8'h83, 8'h08, 8'h12, 8'h34, 16'h1234, 8'd3,  8'd1}, // R6 bit7 ignored
        {8'h23, 8'h08, 8'h12, 8'h34, 16'h1234, 8'd3,  8'd0}, // R3 hidden
        {8'h05, 8'h05, 8'h12, 8'h34, 16'h1234, 8'd5,  8'd0}, // R8 start == end
        {8'h06, 8'h03, 8'h12, 8'h34, 16'h1234, 8'd4,  8'd0}, // R8 start > end
        {8'h00, 8'h08, 8'h12, 8'h34, 16'h1235, 8'd1,  8'd0}, // R9 low byte differs
        {8'h00, 8'h08, 8'h12, 8'h34, 16'h1334, 8'd1,  8'd0}, // R9 high byte differs
        {8'h1F, 8'h20, 8'hAB, 8'hCD, 16'hABCD, 8'd31, 8'd1}, // R7 end 32 permits 31
        {8'h00, 8'h48, 8'h12, 8'h34, 16'h1234, 8'd7,  8'd1}, // R7 end bits 7..6 ignored
        {8'h40, 8'h08, 8'h12, 8'h34, 16'h1234, 8'd0,  8'd1}, // R4 fast, frame 0
        {8'h60, 8'h08, 8'h12, 8'h34, 16'h1234, 8'd0,  8'd1}  // R5 slow, frame 0
    };

    cur_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .mode_cfg    (mode_cfg),
        .end_cfg     (end_cfg),
        .cur_hi      (cur_hi),
        .cur_lo      (cur_lo),
        .cell_addr   (cell_addr),
        .scan_line   (scan_line),
        .cursor_on   (cursor_on)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: cursor_on=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic one_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic set_hit(input logic [7:0] m);
        mode_cfg  = m;
        end_cfg   = 8'h08;
        cur_hi    = 8'h12;
        cur_lo    = 8'h34;
        cell_addr = 16'h1234;
        scan_line = 5'd2;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        // R1: output low during reset even with a matching cursor
        set_hit(8'h00);
        repeat (3) @(negedge clk);
        chk("R1 in reset", cursor_on, 1'b0);
        rst_n = 1'b1;
        cell_addr = 16'h0000;
        @(negedge clk);
        chk("R1 after reset", cursor_on, 1'b0);

        // R10: one-cycle latency
        @(negedge clk) set_hit(8'h00);
        #1 chk("R10 not yet", cursor_on, 1'b0);
        @(negedge clk);
        chk("R10 next cycle", cursor_on, 1'b1);
        cell_addr = 16'h0000;
        #1 chk("R10 holds", cursor_on, 1'b1);
        @(negedge clk);
        chk("R10 falls", cursor_on, 1'b0);

        // Vector table at frame count 0
        for (int i = 0; i < NVEC; i++) begin
            mode_cfg  = VEC[i][63:56];
            end_cfg   = VEC[i][55:48];
            cur_hi    = VEC[i][47:40];
            cur_lo    = VEC[i][39:32];
            cell_addr = VEC[i][31:16];
            scan_line = VEC[i][12:8];
            @(negedge clk);
            chk($sformatf("vector %0d (R2-R9)", i), cursor_on, VEC[i][0]);
        end

        // R4 R5 R2 R11: blink phases across the full counter span and wrap
        for (int k = 0; k < 34; k++) begin
            logic [4:0] kc;
            kc = 5'(k);
            set_hit(8'h40);
            @(negedge clk);
            chk($sformatf("R4 fast frame %0d", k), cursor_on, ~kc[3]);
            set_hit(8'h60);
            @(negedge clk);
            chk($sformatf("R5 slow frame %0d", k), cursor_on, ~kc[4]);
            set_hit(8'h00);
            @(negedge clk);
            chk($sformatf("R2 steady frame %0d", k), cursor_on, 1'b1);
            one_frame();
        end

        // R11: count is 34 mod 32 = 2; idle cycles without pulses keep it
        set_hit(8'h60);
        repeat (40) @(negedge clk);
        chk("R11 idle no advance", cursor_on, 1'b1);
        for (int j = 0; j < 14; j++) one_frame();
        set_hit(8'h60);
        @(negedge clk);
        chk("R11 count 16 slow off", cursor_on, 1'b0);

        // R1: reset clears the counter
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-run", cursor_on, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 counter cleared", cursor_on, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule